// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one I2C master transaction at the byte level. A request carries a target address, a flag that selects 7-bit or 10-bit addressing, a direction bit and a byte count. The sequencer turns it into a series of commands for a separate bit-level bus engine: start, repeated start, stop, write one byte and read one byte. It watches the acknowledge result that comes back for every byte it writes. Payload bytes for a write come in through a valid/ready stream. Received bytes leave through a second valid/ready stream.

The sequencer works out the address phase for both address widths. In 10-bit mode it sends the two header bytes. For a read it also issues a repeated start and sends the header again with the read bit set. On received bytes it asks the engine to acknowledge every byte except the last, so the engine NACKs the final byte. After the last data byte it waits until the bus reports that the byte transfer has finished, and only then issues a stop. When the stop completes, the block gives a one-cycle done pulse. A NACK from the target on any written byte ends the transaction early: the block issues a stop and gives a one-cycle error pulse.

States and their transitions:
- `S_IDLE` goes to `S_START` when a request is accepted.
- `S_START` goes to `S_HDR`.
- `S_HDR` goes to `S_ABORT` on a NACK, to `S_LOW` in 10-bit mode, and otherwise to the data phase.
- `S_LOW` goes to `S_ABORT` on a NACK, to `S_RSTART` for a 10-bit read, and otherwise to the data phase.
- `S_RSTART` goes to `S_HDR_RD`.
- `S_HDR_RD` goes to `S_ABORT` on a NACK, and otherwise to the data phase.

The data phase begins in one of three states. A count of zero goes to `S_STOP`, a read goes to `S_RD_BYTE`, and a write goes to `S_WR_WAIT`.
- `S_WR_WAIT` goes to `S_WR_BYTE` when a write byte arrives.
- `S_WR_BYTE` goes to `S_ABORT` on a NACK, to `S_FIN` after the last byte, and otherwise back to `S_WR_WAIT`.
- `S_RD_BYTE` goes to `S_RD_PUSH`.
- `S_RD_PUSH` goes to `S_FIN` after the last byte has been handed over, and otherwise back to `S_RD_BYTE`.
- `S_FIN` goes to `S_STOP` once the transfer-finished indication is high.
- `S_STOP` goes to `S_DONE`, and `S_ABORT` goes to `S_FAIL`.
- `S_DONE` and `S_FAIL` each last one cycle and return to `S_IDLE`.

A command is posted by holding `cmd_valid` high with `cmd_op` stable. The engine finishes it with a one-cycle `eng_done`. The next command starts no earlier than the cycle after that. Command codes on `cmd_op`: 1 start, 2 repeated start, 3 stop, 4 write byte, 5 read byte, 0 none.

Top module: `i2c_xact_seq`

## Requirements
- R1: In 7-bit mode the byte sent after start is `{addr[6:0], rd}`: the address in bits 7:1 and the direction in bit 0, where 1 means read.
- R2: In 10-bit mode the byte sent after start is `{5'b11110, addr[9:8], 1'b0}` and the second byte is `addr[7:0]`. For a write, the data bytes follow directly after the second byte.
- R3: A 10-bit read sends both address bytes. It then issues a repeated start (code 2) and sends `{5'b11110, addr[9:8], 1'b1}` before the first read command.
- R4: For a read of N bytes, read commands 1 to N-1 carry `cmd_rack`=1 and read command N carries `cmd_rack`=0. When N=1 the only read carries 0.
- R5: After the last data byte of a nonzero transfer, the stop command is not posted until `bus_fin` has been sampled high.
- R6: A NACK (`eng_nack`=1 with `eng_done`) on any address byte or written data byte is followed directly by a stop. After that stop completes, `error` pulses for exactly one cycle and `done` stays low.
- R7: A transaction that succeeds ends with a stop, followed by a `done` pulse that lasts exactly one cycle. `done` and `error` are never high together.
- R8: `req_ready` is high only in the idle state, and a request is accepted only there. Activity on `req_valid` while a transaction runs starts nothing.
- R9: A transfer count of zero sends the address phase and then the stop, with no data command and no stream handshake.
- R10: Each written data byte is taken from the write stream in the order it arrives. Each received byte is offered on `rd_data`, held stable until `rd_ready`, and is the byte the engine returned.
- R11: After reset the block is idle: `req_ready`=1 and `cmd_valid`, `done`, `error`, `wr_ready` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| req_ten | input | 1 | 1 selects 10-bit addressing |
| req_read | input | 1 | 1 selects a read transaction |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Sequencer takes a write byte |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Received byte present |
| rd_ready | input | 1 | Consumer takes the received byte |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command posted to the bus engine |
| cmd_op | output | 3 | Command code |
| cmd_wdata | output | 8 | Byte to send for a write command |
| cmd_rack | output | 1 | For a read command: 1 acknowledges, 0 NACKs |
| eng_done | input | 1 | One-cycle completion of the posted command |
| eng_nack | input | 1 | Target NACKed the written byte (valid with eng_done) |
| eng_rdata | input | 8 | Received byte (valid with eng_done on a read) |
| bus_fin | input | 1 | Last byte transfer has finished on the bus |
| done | output | 1 | One-cycle pulse: transaction completed |
| error | output | 1 | One-cycle pulse: transaction aborted on NACK |

## Verification
The hardest situation to reach is a NACK on the third address byte of a 10-bit read, the one sent after the repeated start. Reaching it needs a target that acknowledges the first two bytes and then refuses the resent header. The bench's engine model counts write commands and answers with a NACK at a chosen index. Sweeping that index across every address byte and every data byte reaches each abort point, and the stop must follow at once. The wait for the transfer-finished signal is hard to see from the ports. The model holds that signal low for a few cycles after each command, and the bench records how long the bus had been quiet when the stop was posted.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int TADDR_W = 10;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_STOP   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_READ   = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_HDR,
        S_LOW,
        S_RSTART,
        S_HDR_RD,
        S_WR_WAIT,
        S_WR_BYTE,
        S_RD_BYTE,
        S_RD_PUSH,
        S_FIN,
        S_STOP,
        S_ABORT,
        S_DONE,
        S_FAIL
    } seq_state_e;

endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
    import i2c_seq_pkg::*;
(
    input  logic [TADDR_W-1:0] taddr,
    input  logic               ten,
    input  logic               rd,
    output logic [BYTE_W-1:0]  first_byte,
    output logic [BYTE_W-1:0]  low_byte,
    output logic [BYTE_W-1:0]  read_hdr
);

    localparam logic [4:0] TEN_MARK = 5'b11110;
    localparam int         SHORT_W  = BYTE_W - 1;

    always_comb begin
        if (ten) begin
            first_byte = {TEN_MARK, taddr[TADDR_W-1:TADDR_W-2], 1'b0};
        end else begin
            first_byte = {taddr[SHORT_W-1:0], rd};
        end
        low_byte = taddr[BYTE_W-1:0];
        read_hdr = {TEN_MARK, taddr[TADDR_W-1:TADDR_W-2], 1'b1};
    end

endmodule

// File: rtl/i2c_seq_count.sv
module i2c_seq_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_last,
    output logic [LEN_W-1:0] remaining
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec) begin
            remaining <= remaining - ONE;
        end
    end

    assign is_zero = (remaining == '0);
    assign is_last = (remaining == ONE);

    // A byte is retired only while some remain (R10 stream accounting).
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remaining != '0));

endmodule

// File: rtl/i2c_seq_hold.sv
module i2c_seq_hold
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_take,
    input  logic [BYTE_W-1:0] wr_in,
    input  logic              rd_take,
    input  logic [BYTE_W-1:0] rd_in,
    output logic [BYTE_W-1:0] wr_q,
    output logic [BYTE_W-1:0] rd_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (wr_take) wr_q <= wr_in;
            if (rd_take) rd_q <= rd_in;
        end
    end

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [9:0]       req_addr,
    input  logic             req_ten,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [7:0]       cmd_wdata,
    output logic             cmd_rack,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    input  logic             bus_fin,
    output logic             done,
    output logic             error
);

    seq_state_e state_q, state_d;

    logic [TADDR_W-1:0] addr_q;
    logic               ten_q;
    logic               rd_q;

    logic [BYTE_W-1:0]  first_byte, low_byte, read_hdr;
    logic [BYTE_W-1:0]  wr_byte, rd_byte;
    logic               cnt_zero, cnt_last;
    logic [LEN_W-1:0]   cnt_rem;

    logic               accept;
    logic               wr_take, rd_take, cnt_dec;
    logic               ack_ok;
    bus_op_e            op_now;
    seq_state_e         data_entry;

    assign accept = (state_q == S_IDLE) && req_valid;
    assign ack_ok = eng_done && !eng_nack;

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            ten_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            ten_q  <= req_ten;
            rd_q   <= req_read;
        end
    end

    i2c_seq_addr u_addr (
        .taddr      (addr_q),
        .ten        (ten_q),
        .rd         (rd_q),
        .first_byte (first_byte),
        .low_byte   (low_byte),
        .read_hdr   (read_hdr)
    );

    assign cnt_dec = ((state_q == S_WR_BYTE) && ack_ok)
                   || ((state_q == S_RD_PUSH) && rd_ready);

    i2c_seq_count #(.LEN_W(LEN_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (req_len),
        .dec       (cnt_dec),
        .is_zero   (cnt_zero),
        .is_last   (cnt_last),
        .remaining (cnt_rem)
    );

    assign wr_take = (state_q == S_WR_WAIT) && wr_valid;
    assign rd_take = (state_q == S_RD_BYTE) && eng_done;

    i2c_seq_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_take (wr_take),
        .wr_in   (wr_data),
        .rd_take (rd_take),
        .rd_in   (eng_rdata),
        .wr_q    (wr_byte),
        .rd_q    (rd_byte)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // first state of the data phase once addressing is complete
    always_comb begin
        if (cnt_zero)  data_entry = S_STOP;
        else if (rd_q) data_entry = S_RD_BYTE;
        else           data_entry = S_WR_WAIT;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_START;
            S_START:   if (eng_done) state_d = S_HDR;
            S_HDR: begin
                if (eng_done) begin
                    if (eng_nack)   state_d = S_ABORT;
                    else if (ten_q) state_d = S_LOW;
                    else            state_d = data_entry;
                end
            end
            S_LOW: begin
                if (eng_done) begin
                    if (eng_nack)  state_d = S_ABORT;
                    else if (rd_q) state_d = S_RSTART;
                    else           state_d = data_entry;
                end
            end
            S_RSTART:  if (eng_done) state_d = S_HDR_RD;
            S_HDR_RD: begin
                if (eng_done) state_d = eng_nack ? S_ABORT : data_entry;
            end
            S_WR_WAIT: if (wr_valid) state_d = S_WR_BYTE;
            S_WR_BYTE: begin
                if (eng_done) begin
                    if (eng_nack)      state_d = S_ABORT;
                    else if (cnt_last) state_d = S_FIN;
                    else               state_d = S_WR_WAIT;
                end
            end
            S_RD_BYTE: if (eng_done) state_d = S_RD_PUSH;
            S_RD_PUSH: begin
                if (rd_ready) state_d = cnt_last ? S_FIN : S_RD_BYTE;
            end
            S_FIN:     if (bus_fin) state_d = S_STOP;
            S_STOP:    if (eng_done) state_d = S_DONE;
            S_ABORT:   if (eng_done) state_d = S_FAIL;
            S_DONE:    state_d = S_IDLE;
            S_FAIL:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        op_now    = OP_NONE;
        cmd_wdata = '0;
        cmd_rack  = 1'b0;
        unique case (state_q)
            S_START:   op_now = OP_START;
            S_HDR:     begin op_now = OP_WRITE; cmd_wdata = first_byte; end
            S_LOW:     begin op_now = OP_WRITE; cmd_wdata = low_byte;   end
            S_RSTART:  op_now = OP_RSTART;
            S_HDR_RD:  begin op_now = OP_WRITE; cmd_wdata = read_hdr;   end
            S_WR_BYTE: begin op_now = OP_WRITE; cmd_wdata = wr_byte;    end
            S_RD_BYTE: begin op_now = OP_READ;  cmd_rack  = !cnt_last;  end
            S_STOP, S_ABORT: op_now = OP_STOP;
            default:   op_now = OP_NONE;
        endcase
    end

    assign cmd_op    = op_now;
    assign cmd_valid = (op_now != OP_NONE);
    assign req_ready = (state_q == S_IDLE);
    assign wr_ready  = (state_q == S_WR_WAIT);
    assign rd_valid  = (state_q == S_RD_PUSH);
    assign rd_data   = rd_byte;
    assign done      = (state_q == S_DONE);
    assign error     = (state_q == S_FAIL);

    // ---------------- assertions ----------------
    assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_valid && cmd_op == OP_START));

    assert_nack_then_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRITE && eng_done && eng_nack)
            |=> (cmd_valid && cmd_op == OP_STOP));

    assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_op == OP_STOP && eng_done));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_fin_before_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIN && !bus_fin) |=> !(cmd_valid && cmd_op == OP_STOP));

    assert_last_read_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && cnt_rem == LEN_W'(1)) |-> !cmd_rack);

endmodule

// File: tb/test_i2c_xact_seq.sv
module test_i2c_xact_seq;
    localparam int LEN_W = 8;
    localparam int LAT   = 2;
    localparam int FINLAT = 4;
    localparam int LOGN  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             req_valid = 1'b0, req_ten = 1'b0, req_read = 1'b0;
    logic [9:0]       req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_ready, wr_valid, wr_ready, rd_valid, rd_ready;
    logic [7:0]       wr_data, rd_data, cmd_wdata;
    logic             cmd_valid, cmd_rack, done, error, bus_fin;
    logic [2:0]       cmd_op;
    logic             eng_done, eng_nack;
    logic [7:0]       eng_rdata;

    logic tb_clr = 1'b0;
    int   nack_at = -1;

    i2c_xact_seq #(.LEN_W(LEN_W)) i_i2c_xact_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_ten(req_ten), .req_read(req_read), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_rack(cmd_rack), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rdata(eng_rdata), .bus_fin(bus_fin), .done(done), .error(error)
    );

    // ---------------- engine model and stream endpoints ----------------
    int   cyc = 0;
    logic busy;
    int   tmr, fin_cnt, rd_cnt, wcmd_cnt, wr_idx, rx_n, lg_n;
    logic [2:0] cur_op;
    logic [2:0] lg_op  [LOGN];
    logic [7:0] lg_dat [LOGN];
    logic       lg_ack [LOGN];
    int         lg_gap [LOGN];
    logic [7:0] rx_dat [LOGN];

    assign bus_fin  = !busy && (fin_cnt >= FINLAT);
    assign wr_valid = (cyc % 8) != 3;
    assign wr_data  = 8'h5A + 8'(wr_idx * 3);
    assign rd_ready = (cyc % 4) != 1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (!rst_n || tb_clr) begin
            busy <= 1'b0; tmr <= 0; eng_done <= 1'b0; eng_nack <= 1'b0;
            eng_rdata <= '0; fin_cnt <= 0; rd_cnt <= 0; wcmd_cnt <= 0;
            lg_n <= 0; cur_op <= '0; wr_idx <= 0; rx_n <= 0;
        end else begin
            eng_done <= 1'b0;
            if (eng_done) begin
                busy <= 1'b0; fin_cnt <= 0;
            end else if (fin_cnt < 15) begin
                fin_cnt <= fin_cnt + 1;
            end
            if (!busy && cmd_valid) begin
                busy <= 1'b1; tmr <= 0; cur_op <= cmd_op;
                if (lg_n < LOGN) begin
                    lg_op[lg_n] <= cmd_op; lg_dat[lg_n] <= cmd_wdata;
                    lg_ack[lg_n] <= cmd_rack; lg_gap[lg_n] <= fin_cnt;
                end
                lg_n <= lg_n + 1;
            end else if (busy && !eng_done) begin
                if (tmr == LAT) begin
                    eng_done <= 1'b1;
                    eng_nack <= (cur_op == 3'd4) && (wcmd_cnt == nack_at);
                    if (cur_op == 3'd4) wcmd_cnt <= wcmd_cnt + 1;
                    eng_rdata <= 8'h3C ^ 8'(rd_cnt * 17);
                    if (cur_op == 3'd5) rd_cnt <= rd_cnt + 1;
                end else begin
                    tmr <= tmr + 1;
                end
            end
            if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
            if (rd_valid && rd_ready) begin
                if (rx_n < LOGN) rx_dat[rx_n] <= rd_data;
                rx_n <= rx_n + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [2:0] e_op  [LOGN];
    logic [7:0] e_dat [LOGN];
    logic       e_ack [LOGN];
    int         e_n;

    task automatic epush(input logic [2:0] op, input logic [7:0] d, input logic a);
        e_op[e_n] = op; e_dat[e_n] = d; e_ack[e_n] = a; e_n++;
    endtask

    task automatic run_txn(input logic [9:0] a, input bit ten, input bit rd,
                           input int len, input int nk, input bit spam);
        int  wc;
        bit  ab;
        int  dn, er, t, post, nwr;
        bit  seen;
        string tag;
        @(negedge clk); tb_clr = 1'b1; nack_at = nk;
        @(negedge clk); tb_clr = 1'b0;
        chk(req_ready == 1'b1, "R8", "ready in idle", req_ready, 1);
        req_addr = a; req_ten = ten; req_read = rd; req_len = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = spam;
        if (spam) begin
            req_addr = ~a; req_ten = ~ten; req_read = ~rd; req_len = 8'd9;
        end
        dn = 0; er = 0; t = 0; post = 0; seen = 0;
        while (post < 4 && t < 3000) begin
            @(negedge clk); t++;
            if (done) dn++;
            if (error) er++;
            if (done || error) begin seen = 1; req_valid = 1'b0; end
            if (seen) post++;
        end
        req_valid = 1'b0;
        chk(seen, "R7", "transaction end seen", int'(seen), 1);

        // expected command sequence, built from the requirements
        e_n = 0; wc = 0; ab = 0; nwr = 0;
        tag = ten ? (rd ? "R3" : "R2") : "R1";
        epush(3'd1, 8'h00, 1'b0);
        epush(3'd4, ten ? {5'b11110, a[9:8], 1'b0} : {a[6:0], rd}, 1'b0);
        if (nk == wc) ab = 1; wc++;
        if (!ab && ten) begin
            epush(3'd4, a[7:0], 1'b0);
            if (nk == wc) ab = 1; wc++;
            if (!ab && rd) begin
                epush(3'd2, 8'h00, 1'b0);
                epush(3'd4, {5'b11110, a[9:8], 1'b1}, 1'b0);
                if (nk == wc) ab = 1; wc++;
            end
        end
        if (!ab) begin
            for (int i = 0; i < len; i++) begin
                if (rd) begin
                    epush(3'd5, 8'h00, (i < len - 1));
                end else begin
                    epush(3'd4, 8'h5A + 8'(i * 3), 1'b0);
                    nwr++;
                    if (nk == wc) begin ab = 1; wc++; break; end
                    wc++;
                end
            end
        end
        epush(3'd3, 8'h00, 1'b0);
        if (ab) tag = "R6";
        else if (len == 0) tag = "R9";

        chk(lg_n == e_n, tag, "command count", lg_n, e_n);
        for (int i = 0; i < e_n && i < lg_n; i++) begin
            chk(lg_op[i] == e_op[i], tag, "command code", lg_op[i], e_op[i]);
            if (e_op[i] == 3'd4)
                chk(lg_dat[i] == e_dat[i], tag, "written byte", lg_dat[i], e_dat[i]);
            if (e_op[i] == 3'd5)
                chk(lg_ack[i] == e_ack[i], "R4", "read ack flag", lg_ack[i], e_ack[i]);
        end
        if (ab) begin
            chk(er == 1 && dn == 0, "R6", "error pulse count", er * 16 + dn, 16);
        end else begin
            chk(dn == 1 && er == 0, "R7", "done pulse count", dn * 16 + er, 16);
            if (len > 0 && lg_n == e_n)
                chk(lg_gap[lg_n-1] >= FINLAT, "R5", "stop after bus_fin",
                    lg_gap[lg_n-1], FINLAT);
        end
        chk(wr_idx == nwr, (len == 0) ? "R9" : "R10", "write bytes taken", wr_idx, nwr);
        if (rd && !ab) begin
            chk(rx_n == len, (len == 0) ? "R9" : "R10", "bytes delivered", rx_n, len);
            for (int i = 0; i < len && i < rx_n; i++)
                chk(rx_dat[i] == (8'h3C ^ 8'(i * 17)), "R10", "received byte",
                    rx_dat[i], 8'h3C ^ 8'(i * 17));
        end
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R8", "idle after end",
            {req_ready, cmd_valid}, 2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
        chk(!cmd_valid && !done && !error && !wr_ready && !rd_valid, "R11",
            "reset outputs quiet", {cmd_valid, done, error, wr_ready, rd_valid}, 0);

        // sweep of address mode, direction and count
        for (int ten = 0; ten < 2; ten++)
            for (int rd = 0; rd < 2; rd++)
                for (int len = 0; len < 5; len++)
                    run_txn(ten ? (10'h2A5 ^ 10'(len * 37)) : (10'(7'h5B + 7'(len * 11))),
                            ten[0], rd[0], len, -1, len[0]);

        // NACK at every address byte of a 10-bit read
        for (int k = 0; k < 3; k++) run_txn(10'h1C3, 1'b1, 1'b1, 3, k, 1'b0);
        // NACK at every byte of a 10-bit write
        for (int k = 0; k < 5; k++) run_txn(10'h3F0, 1'b1, 1'b0, 3, k, 1'b1);
        // NACK at every byte of a 7-bit write
        for (int k = 0; k < 3; k++) run_txn(10'h07F, 1'b0, 1'b0, 2, k, 1'b0);
        // longer read to stress ack policy and stream stalls
        run_txn(10'h012, 1'b0, 1'b1, 9, -1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule